// File: doc/BRIEF.md
# Head Load and Unload Sequencer

This block sequences the head-load output of a floppy drive interface around read and write operations. An operation that starts while the head is unloaded first drives a short pulse on the drive's fault-reset line. It then raises head load and counts a programmable settling time before it tells the operation logic that transfers may begin. When the operation finishes, the head stays loaded for a programmable unload time. A command that arrives inside that window reuses the loaded head at once, with no fault-reset pulse and no settling wait.

Both delays are counted on a 1 ms tick input that the surrounding logic supplies. The load delay is set by a 7-bit field in units of 2 ms, and the unload delay by a 4-bit field in units of 16 ms. A field value of zero selects one unit. The two fields are written together through a setup strobe and are kept across reset. The block also raises a low-current output while the current cylinder is 42 or higher.

Top module: `hd_load_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after a reset edge, head_load, fault_reset, load_ready and low_current are 0 and idle is 1. A reset also drops a head that is loaded.
- R2: op_start while idle drives fault_reset high for exactly FRST_CYC clock cycles (default 4). head_load rises on the cycle after fault_reset falls, and never while fault_reset is high.
- R3: After head_load rises, load_ready goes high on the cycle after the (2 x L)-th tick counted, where L is the load field. A field of 0 counts as 1 (2 ticks).
- R4: load_ready is high for exactly one clock. head_load is high whenever load_ready is high.
- R5: op_end during an active operation keeps the head loaded. On the cycle after the (16 x U)-th following tick, where U is the unload field and 0 counts as 1, head_load falls and idle rises together.
- R6: op_start while the unload count is running produces no fault-reset pulse and no gap in head_load. load_ready pulses on the cycle after op_start.
- R7: op_start during the fault-reset pulse, during the load wait or during an active operation has no effect on the sequence. op_end outside an active operation is ignored.
- R8: low_current is 1 on the cycle after cylinder is 42 or greater, and 0 on the cycle after it is below 42.
- R9: Reset does not change the programmed load and unload fields.
- R10: A cycle with spec_we high captures spec_load_field and spec_unload_field together. The new values apply to the next delay that starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| spec_we | input | 1 | Write strobe for the timing fields |
| spec_load_field | input | 7 | Load delay in 2 ms units, 0 means 1 |
| spec_unload_field | input | 4 | Unload delay in 16 ms units, 0 means 1 |
| op_start | input | 1 | A read or write operation begins |
| op_end | input | 1 | The active operation has finished |
| cylinder | input | 8 | Current cylinder number |
| fault_reset | output | 1 | Fault-reset pulse issued before a load |
| head_load | output | 1 | Head load to the drive |
| load_ready | output | 1 | One-cycle pulse: transfers may begin |
| idle | output | 1 | Head unloaded and no operation pending |
| low_current | output | 1 | Cylinder is at or beyond the low-current threshold |

## Verification
The bench counts ticks at the exact boundary of each delay. A counter that is off by one shows up as load_ready or the unload moving one tick early or late. Zero fields are tested on both delays, so a design that treats zero as a 0 ms delay, or as the maximum, misses the 2-tick and 16-tick expectations. A new operation started inside the unload window must not produce a second fault-reset pulse or a dip in head_load, and stray op_start or op_end pulses sent mid-sequence must not restart or shorten any count. A reset is applied between programming and use to confirm that the timing fields are kept, and the low-current output is checked just below and at the threshold cylinder.

// File: rtl/hlt_pkg.sv
`timescale 1ns/1ps
package hlt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FRST   = 3'd1,
        ST_LOAD   = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_HOLD   = 3'd4
    } hl_state_e;

    localparam int DEF_LOAD_W      = 7;
    localparam int DEF_UNLOAD_W    = 4;
    localparam int DEF_LOAD_UNIT   = 2;
    localparam int DEF_UNLOAD_UNIT = 16;
    localparam int DEF_FRST_CYC    = 4;
    localparam int DEF_CYL_W       = 8;
    localparam int DEF_LOWCUR_CYL  = 42;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hlt_spec_reg.sv
`timescale 1ns/1ps
module hlt_spec_reg #(
    parameter int LOAD_W      = hlt_pkg::DEF_LOAD_W,
    parameter int UNLOAD_W    = hlt_pkg::DEF_UNLOAD_W,
    parameter int LOAD_UNIT   = hlt_pkg::DEF_LOAD_UNIT,
    parameter int UNLOAD_UNIT = hlt_pkg::DEF_UNLOAD_UNIT,
    parameter int CNT_W       = 8
) (
    input  logic                clk,
    input  logic                spec_we,
    input  logic [LOAD_W-1:0]   load_field,
    input  logic [UNLOAD_W-1:0] unload_field,
    output logic [CNT_W-1:0]    load_target,
    output logic [CNT_W-1:0]    unload_target
);
    // Timing fields are deliberately kept out of reset.
    logic [LOAD_W-1:0]   load_q;
    logic [UNLOAD_W-1:0] unload_q;

    always_ff @(posedge clk) begin
        if (spec_we) begin
            load_q   <= load_field;
            unload_q <= unload_field;
        end
    end

    logic [CNT_W-1:0] load_units;
    logic [CNT_W-1:0] unload_units;

    always_comb begin
        load_units    = (load_q == '0)   ? CNT_W'(1) : CNT_W'(load_q);
        unload_units  = (unload_q == '0) ? CNT_W'(1) : CNT_W'(unload_q);
        load_target   = load_units * CNT_W'(LOAD_UNIT);
        unload_target = unload_units * CNT_W'(UNLOAD_UNIT);
    end

endmodule

// File: rtl/hlt_timer.sv
`timescale 1ns/1ps
module hlt_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ev,
    input  logic [CNT_W-1:0] target,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = ev && (cnt_q == target - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (ev) begin
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R3
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ev && target != '0) |-> (cnt_q < target));

endmodule

// File: rtl/hlt_seq.sv
`timescale 1ns/1ps
module hlt_seq #(
    parameter int CNT_W    = 8,
    parameter int FRST_CYC = hlt_pkg::DEF_FRST_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             op_start,
    input  logic             op_end,
    input  logic             done,
    input  logic [CNT_W-1:0] load_target,
    input  logic [CNT_W-1:0] unload_target,
    output logic             ev,
    output logic             clr,
    output logic [CNT_W-1:0] target,
    output logic             fault_reset,
    output logic             head_load,
    output logic             load_ready,
    output logic             idle
);
    import hlt_pkg::*;

    hl_state_e st_q, st_nxt;
    logic      rdy_q;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   if (op_start) st_nxt = ST_FRST;
            ST_FRST:   if (done)     st_nxt = ST_LOAD;
            ST_LOAD:   if (done)     st_nxt = ST_ACTIVE;
            ST_ACTIVE: if (op_end)   st_nxt = ST_HOLD;
            ST_HOLD: begin
                if (op_start)  st_nxt = ST_ACTIVE;
                else if (done) st_nxt = ST_IDLE;
            end
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_FRST: target = CNT_W'(FRST_CYC);
            ST_LOAD: target = load_target;
            ST_HOLD: target = unload_target;
            default: target = '0;
        endcase
        ev  = (st_q == ST_FRST) || (((st_q == ST_LOAD) || (st_q == ST_HOLD)) && tick);
        clr = (st_nxt != st_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            rdy_q <= 1'b0;
        end else begin
            st_q  <= st_nxt;
            rdy_q <= ((st_q == ST_LOAD) && done) || ((st_q == ST_HOLD) && op_start);
        end
    end

    assign fault_reset = (st_q == ST_FRST);
    assign head_load   = (st_q == ST_LOAD) || (st_q == ST_ACTIVE) || (st_q == ST_HOLD);
    assign idle        = (st_q == ST_IDLE);
    assign load_ready  = rdy_q;

    // R2
    frst_before_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(head_load) |-> $past(fault_reset));
    // R2
    frst_then_load_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_reset) |-> head_load);
    // R4
    ready_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        load_ready |=> !load_ready);
    // R4
    ready_with_head_chk: assert property (@(posedge clk) disable iff (rst)
        load_ready |-> head_load);
    // R5
    idle_excl_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!head_load && !fault_reset));
    // R6
    reuse_no_frst_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_HOLD) && op_start) |=> (head_load && !fault_reset && load_ready));

endmodule

// File: rtl/hd_load_ctrl.sv
`timescale 1ns/1ps
module hd_load_ctrl #(
    parameter int LOAD_W      = hlt_pkg::DEF_LOAD_W,
    parameter int UNLOAD_W    = hlt_pkg::DEF_UNLOAD_W,
    parameter int LOAD_UNIT   = hlt_pkg::DEF_LOAD_UNIT,
    parameter int UNLOAD_UNIT = hlt_pkg::DEF_UNLOAD_UNIT,
    parameter int FRST_CYC    = hlt_pkg::DEF_FRST_CYC,
    parameter int CYL_W       = hlt_pkg::DEF_CYL_W,
    parameter int LOWCUR_CYL  = hlt_pkg::DEF_LOWCUR_CYL
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_1ms,
    input  logic                spec_we,
    input  logic [LOAD_W-1:0]   spec_load_field,
    input  logic [UNLOAD_W-1:0] spec_unload_field,
    input  logic                op_start,
    input  logic                op_end,
    input  logic [CYL_W-1:0]    cylinder,
    output logic                fault_reset,
    output logic                head_load,
    output logic                load_ready,
    output logic                idle,
    output logic                low_current
);
    localparam int LOAD_MAX   = ((1 << LOAD_W) - 1) * LOAD_UNIT;
    localparam int UNLOAD_MAX = ((1 << UNLOAD_W) - 1) * UNLOAD_UNIT;
    localparam int MAX_T      = hlt_pkg::max3(LOAD_MAX, UNLOAD_MAX, FRST_CYC);
    localparam int CNT_W      = $clog2(MAX_T + 1);

    logic [CNT_W-1:0] load_target, unload_target, target;
    logic             ev, clr, done;

    hlt_spec_reg #(
        .LOAD_W(LOAD_W), .UNLOAD_W(UNLOAD_W),
        .LOAD_UNIT(LOAD_UNIT), .UNLOAD_UNIT(UNLOAD_UNIT), .CNT_W(CNT_W)
    ) u_spec (
        .clk(clk), .spec_we(spec_we),
        .load_field(spec_load_field), .unload_field(spec_unload_field),
        .load_target(load_target), .unload_target(unload_target)
    );

    hlt_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .clr(clr), .ev(ev), .target(target), .done(done)
    );

    hlt_seq #(.CNT_W(CNT_W), .FRST_CYC(FRST_CYC)) u_seq (
        .clk(clk), .rst(rst), .tick(tick_1ms),
        .op_start(op_start), .op_end(op_end), .done(done),
        .load_target(load_target), .unload_target(unload_target),
        .ev(ev), .clr(clr), .target(target),
        .fault_reset(fault_reset), .head_load(head_load),
        .load_ready(load_ready), .idle(idle)
    );

    logic lc_q;
    always_ff @(posedge clk) begin
        if (rst) lc_q <= 1'b0;
        else     lc_q <= (cylinder >= CYL_W'(LOWCUR_CYL));
    end
    assign low_current = lc_q;

    // R8
    lowcur_high_chk: assert property (@(posedge clk) disable iff (rst)
        (cylinder >= CYL_W'(LOWCUR_CYL)) |=> low_current);
    // R8
    lowcur_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cylinder < CYL_W'(LOWCUR_CYL)) |=> !low_current);

endmodule

// File: tb/hd_load_ctrl_bench.sv
`timescale 1ns/1ps
module hd_load_ctrl_bench;
    logic       clk = 1'b0, rst = 1'b1, tick = 1'b0, spec_we = 1'b0;
    logic       op_start = 1'b0, op_end = 1'b0;
    logic [6:0] f_load = '0;
    logic [3:0] f_unl = '0;
    logic [7:0] cyl = '0;
    logic       fault_reset, head_load, load_ready, idle, low_current;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    hd_load_ctrl u_hd_load_ctrl (
        .clk(clk), .rst(rst), .tick_1ms(tick), .spec_we(spec_we),
        .spec_load_field(f_load), .spec_unload_field(f_unl),
        .op_start(op_start), .op_end(op_end), .cylinder(cyl),
        .fault_reset(fault_reset), .head_load(head_load),
        .load_ready(load_ready), .idle(idle), .low_current(low_current)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    task automatic program_fields(int fl, int fu);
        f_load = 7'(fl); f_unl = 4'(fu); spec_we = 1'b1;
        @(negedge clk); spec_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; repeat (2) @(negedge clk);
        chk("R1 head_load in reset", head_load, 0);
        chk("R1 idle in reset", idle, 1);
        rst = 1'b0; @(negedge clk);
        chk("R1 fault_reset after reset", fault_reset, 0);
        chk("R1 load_ready after reset", load_ready, 0);
        chk("R1 low_current after reset", low_current, 0);
    endtask

    task automatic frst_phase(string req, bit poke);
        op_start = 1'b1; @(negedge clk);
        op_start = poke;
        chk({req, " R2 fault_reset 1"}, fault_reset, 1);
        chk({req, " R2 no head during pulse"}, head_load, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); op_start = 1'b0;
            chk({req, " R2 fault_reset held"}, fault_reset, 1);
        end
        @(negedge clk);
        chk({req, " R2 fault_reset ends"}, fault_reset, 0);
        chk({req, " R2 head_load rises"}, head_load, 1);
    endtask

    task automatic load_phase(string req, int n, bit poke);
        for (int i = 0; i < n - 1; i++) begin
            pulse_tick();
            chk({req, " R3 no early ready"}, load_ready, 0);
            if (poke && i == 0) begin
                op_start = 1'b1; op_end = 1'b1; @(negedge clk);
                op_start = 1'b0; op_end = 1'b0;
                chk({req, " R7 poke in load wait"}, load_ready + fault_reset, 0);
            end
        end
        pulse_tick();
        chk({req, " R3 ready on last tick"}, load_ready, 1);
        chk({req, " R4 head with ready"}, head_load, 1);
        @(negedge clk);
        chk({req, " R4 ready one cycle"}, load_ready, 0);
    endtask

    task automatic unload_phase(string req, int n);
        op_end = 1'b1; @(negedge clk); op_end = 1'b0;
        chk({req, " R5 head held after end"}, head_load, 1);
        for (int i = 0; i < n - 1; i++) begin
            pulse_tick();
            if (head_load != 1'b1 || idle != 1'b0)
                chk({req, " R5 early unload"}, 0, 1);
        end
        checks++;
        pulse_tick();
        chk({req, " R5 head drops on last tick"}, head_load, 0);
        chk({req, " R5 idle rises"}, idle, 1);
    endtask

    task automatic t_basic();
        program_fields(3, 1);
        frst_phase("basic", 1'b0);
        load_phase("basic R10", 6, 1'b0);
        unload_phase("basic", 16);
    endtask

    task automatic t_reuse();
        frst_phase("reuse", 1'b0);
        load_phase("reuse", 6, 1'b0);
        op_end = 1'b1; @(negedge clk); op_end = 1'b0;
        repeat (5) pulse_tick();
        op_start = 1'b1; @(negedge clk); op_start = 1'b0;
        chk("R6 no fault pulse on reuse", fault_reset, 0);
        chk("R6 head stays on reuse", head_load, 1);
        chk("R6 ready after reuse start", load_ready, 1);
        @(negedge clk);
        chk("R6 ready one cycle", load_ready, 0);
        unload_phase("reuse", 16);
    endtask

    task automatic t_ignore();
        frst_phase("ignore R7", 1'b1);
        load_phase("ignore R7", 6, 1'b1);
        op_start = 1'b1; @(negedge clk); op_start = 1'b0;
        chk("R7 start while active no ready", load_ready, 0);
        chk("R7 start while active no pulse", fault_reset, 0);
        unload_phase("ignore", 16);
        op_end = 1'b1; @(negedge clk); op_end = 1'b0;
        chk("R7 end while idle", idle, 1);
    endtask

    task automatic t_zero();
        program_fields(0, 0);
        frst_phase("zero", 1'b0);
        load_phase("zero R3", 2, 1'b0);
        unload_phase("zero", 16);
    endtask

    task automatic t_keep();
        program_fields(2, 1);
        do_reset();
        frst_phase("keep R9", 1'b0);
        load_phase("keep R9", 4, 1'b0);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 reset drops loaded head", head_load, 0);
        chk("R1 idle after reset", idle, 1);
    endtask

    task automatic t_lowcur();
        cyl = 8'd41;  @(negedge clk); chk("R8 cyl 41", low_current, 0);
        cyl = 8'd42;  @(negedge clk); chk("R8 cyl 42", low_current, 1);
        cyl = 8'd200; @(negedge clk); chk("R8 cyl 200", low_current, 1);
        cyl = 8'd10;  @(negedge clk); chk("R8 cyl 10", low_current, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_basic();
        t_reuse();
        t_ignore();
        t_zero();
        t_keep();
        t_lowcur();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule